// File: doc/BRIEF.md
# Vectored Interrupt Controller with Wake-up

This block collects interrupt events for a small 8-bit core. It takes single-cycle event pulses from four timer overflow channels, four comparator change channels, an external interrupt pin and an IR output event. A built-in pin-change detector watches an input port. Every event sets a bit in a flag register. A mask register selects which flags may raise a request. The core reads the flags ANDed with the mask.

A global enable bit decides whether a pending, unmasked flag is taken. The core sets this bit with an enable strobe or a return strobe, and clears it with a disable strobe. When the controller takes an interrupt, it gives a fixed vector chosen by priority, clears global enable, and saves the accumulator and status register into one shadow set. A nested interrupt overwrites that set. The return strobe asks the core to restore it.

While the core sleeps, an unmasked pin-change flag raises a wake request whatever the state of global enable.

Top module: `vic_wake`

## Requirements
- R1: After reset, the flag register, the mask register, global enable and the pin-change reference are all zero, so `status_rd`, `irq_take` and `wake` are 0.
- R2: A timer, comparator, external or pin-change event sets its flag at the next clock edge, whatever the mask or global enable. Flag bits are: 0 external, 1 pin change, 2..5 timer 0..3, 6..9 comparator 0..3, 10 IR.
- R3: The IR flag (bit 10) is set by `ir_evt` only while mask bit 10 is 1. Otherwise the event is dropped.
- R4: `status_rd` always equals the flag register ANDed with the mask register.
- R5: `flag_wr` replaces the flags with `flag_wdata`. A source event in the same cycle still sets its bit.
- R6: `eni` or `reti` sets global enable and `disi` clears it. When `disi` comes in the same cycle as `eni`, global enable stays cleared.
- R7: `irq_take` and `ctx_save` are high while global enable is on and any flag in `status_rd` is set. The take clears global enable at the next edge. A flag that is not cleared causes a new take after `reti`.
- R8: `irq_vector` comes from the lowest set bit of `status_rd`. Bits 0 and 1 give 0x3FE. Timer n gives 0x3FA-2n. Comparator n gives 0x3F2-2n. IR gives 0x3FC.
- R9: The pin-change flag is set while `port_pins` differs from a reference. The reference is loaded from `port_pins` when `port_rd` is high.
- R10: `wake` is high while `sleeping` is high and the pin-change flag and its mask bit are both 1, even with global enable off, in which case no take occurs.
- R11: `acc_i` and `stat_i` are saved at the edge that ends a take and appear on `acc_rst`/`stat_rst`. A later take overwrites them. `ctx_restore` follows `reti`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_ovf | input | NTMR | Timer overflow pulses |
| cmp_chg | input | NCMP | Comparator change pulses |
| ext_evt | input | 1 | External pin event pulse |
| ir_evt | input | 1 | IR output event pulse |
| port_pins | input | PORT_W | Watched input port |
| port_rd | input | 1 | Port read strobe (loads pin-change reference) |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | NTMR+NCMP+3 | Flag write data |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | NTMR+NCMP+3 | Mask write data |
| status_rd | output | NTMR+NCMP+3 | Flags AND mask |
| eni | input | 1 | Global enable set strobe |
| disi | input | 1 | Global enable clear strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| sleeping | input | 1 | Core is in sleep mode |
| acc_i | input | DW | Accumulator value to save |
| stat_i | input | DW | Status register value to save |
| irq_take | output | 1 | Interrupt taken this cycle |
| irq_vector | output | VW | Vector address |
| wake | output | 1 | Wake request |
| ctx_save | output | 1 | Context save strobe |
| ctx_restore | output | 1 | Context restore strobe |
| acc_rst | output | DW | Saved accumulator |
| stat_rst | output | DW | Saved status register |

## Verification
Two collisions matter in this block. A software flag write can arrive in the same cycle as a source event. A disable strobe can arrive in the same cycle as an enable strobe. The bench drives each pair on one clock edge. It then checks that the event bit survives the write, and that no take follows the enable/disable pair while an unmasked flag waits. A third case is a return strobe that meets a flag that was never cleared. The bench checks this through a second take, and confirms that the second take overwrites the shadow set.

// File: rtl/vic_wake.sv
module vic_wake #(
  parameter int PORT_W  = 8,
  parameter int NTMR    = 4,
  parameter int NCMP    = 4,
  parameter int DW      = 8,
  parameter int VW      = 10,
  parameter int COM_VEC = 'h3FE,
  parameter int IR_VEC  = 'h3FC,
  parameter int TMR_VEC = 'h3FA,
  parameter int CMP_VEC = 'h3F2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NTMR-1:0]        tmr_ovf,
  input  logic [NCMP-1:0]        cmp_chg,
  input  logic                   ext_evt,
  input  logic                   ir_evt,
  input  logic [PORT_W-1:0]      port_pins,
  input  logic                   port_rd,
  input  logic                   flag_wr,
  input  logic [NTMR+NCMP+2:0]   flag_wdata,
  input  logic                   mask_wr,
  input  logic [NTMR+NCMP+2:0]   mask_wdata,
  output logic [NTMR+NCMP+2:0]   status_rd,
  input  logic                   eni,
  input  logic                   disi,
  input  logic                   reti,
  input  logic                   sleeping,
  input  logic [DW-1:0]          acc_i,
  input  logic [DW-1:0]          stat_i,
  output logic                   irq_take,
  output logic [VW-1:0]          irq_vector,
  output logic                   wake,
  output logic                   ctx_save,
  output logic                   ctx_restore,
  output logic [DW-1:0]          acc_rst,
  output logic [DW-1:0]          stat_rst
);
  localparam int NF  = NTMR + NCMP + 3;
  localparam int IRB = NF - 1;
  localparam int PCB = 1;

  logic [NF-1:0]     flags, mask, evt, pend;
  logic [PORT_W-1:0] pref;
  logic              gie;
  logic [DW-1:0]     acc_sh, stat_sh;
  logic [VW-1:0]     vec;

  assign evt = {ir_evt & mask[IRB], cmp_chg, tmr_ovf, |(port_pins ^ pref), ext_evt};
  assign pend = flags & mask;
  assign status_rd = pend;
  assign irq_take = gie & |pend;
  assign ctx_save = irq_take;
  assign ctx_restore = reti;
  assign wake = sleeping & pend[PCB];
  assign acc_rst = acc_sh;
  assign stat_rst = stat_sh;
  assign irq_vector = vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
      pref  <= '0;
      gie   <= 1'b0;
    end else begin
      flags <= (flag_wr ? flag_wdata : flags) | evt;
      if (mask_wr) mask <= mask_wdata;
      if (port_rd) pref <= port_pins;
      if (disi || irq_take) gie <= 1'b0;
      else if (eni || reti) gie <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_sh  <= '0;
      stat_sh <= '0;
    end else if (irq_take) begin
      acc_sh  <= acc_i;
      stat_sh <= stat_i;
    end
  end

  always_comb begin
    vec = VW'(IR_VEC);
    for (int i = NF - 1; i >= 0; i--) begin
      if (pend[i]) begin
        if (i < 2)              vec = VW'(COM_VEC);
        else if (i < 2 + NTMR)  vec = VW'(TMR_VEC - 2 * (i - 2));
        else if (i < IRB)       vec = VW'(CMP_VEC - 2 * (i - 2 - NTMR));
        else                    vec = VW'(IR_VEC);
      end
    end
  end
endmodule

// File: rtl/vic_wake_chk.sv
module vic_wake_chk #(
  parameter int NF = 11,
  parameter int DW = 8,
  parameter int VW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_take,
  input logic          eni,
  input logic          reti,
  input logic          disi,
  input logic          gie,
  input logic          tmr0,
  input logic [NF-1:0] flags,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] acc_sh,
  input logic          wake,
  input logic          sleeping,
  input logic [VW-1:0] irq_vector
);
  // R7
  take_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take && !eni && !reti |=> !irq_take);
  // R6
  disi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disi |=> !gie);
  // R2
  tmr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0 |=> flags[2]);
  // R11
  ctx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> acc_sh == $past(acc_i));
  // R10
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> sleeping);
  // R8
  vec_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_vector[0] == 1'b0);
endmodule

bind vic_wake vic_wake_chk #(.NF(NF), .DW(DW), .VW(VW)) u_vic_wake_chk (
  .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .eni(eni), .reti(reti),
  .disi(disi), .gie(gie), .tmr0(tmr_ovf[0]), .flags(flags), .acc_i(acc_i),
  .acc_sh(acc_sh), .wake(wake), .sleeping(sleeping), .irq_vector(irq_vector)
);

// File: tb/test_vic_wake.sv
module test_vic_wake;
  logic clk = 0, rst_n = 0;
  logic [3:0] tmr_ovf = 0, cmp_chg = 0;
  logic ext_evt = 0, ir_evt = 0, port_rd = 0, flag_wr = 0, mask_wr = 0;
  logic [7:0] port_pins = 0, acc_i = 0, stat_i = 0;
  logic [10:0] flag_wdata = 0, mask_wdata = 0, status_rd;
  logic eni = 0, disi = 0, reti = 0, sleeping = 0;
  logic irq_take, wake, ctx_save, ctx_restore;
  logic [9:0] irq_vector;
  logic [7:0] acc_rst, stat_rst;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vic_wake i_vic_wake (
    .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .cmp_chg(cmp_chg),
    .ext_evt(ext_evt), .ir_evt(ir_evt), .port_pins(port_pins), .port_rd(port_rd),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .status_rd(status_rd), .eni(eni), .disi(disi),
    .reti(reti), .sleeping(sleeping), .acc_i(acc_i), .stat_i(stat_i),
    .irq_take(irq_take), .irq_vector(irq_vector), .wake(wake),
    .ctx_save(ctx_save), .ctx_restore(ctx_restore), .acc_rst(acc_rst),
    .stat_rst(stat_rst)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_flags(logic [10:0] v);
    flag_wr = 1; flag_wdata = v; tick(); flag_wr = 0;
  endtask

  task automatic wr_mask(logic [10:0] v);
    mask_wr = 1; mask_wdata = v; tick(); mask_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_rd, 0);
    chk("R1 take", irq_take, 0);
    chk("R1 wake", wake, 0);
    wr_mask(11'h7FF);
    chk("R1 flags zero, pin ref zero", status_rd, 0);
    wr_mask(0);
  endtask

  task automatic t_masked_latch();
    tmr_ovf = 4'b0010; cmp_chg = 4'b0100; ext_evt = 1; tick();
    tmr_ovf = 0; cmp_chg = 0; ext_evt = 0;
    chk("R4 masked status", status_rd, 0);
    chk("R2 no take when masked", irq_take, 0);
    wr_mask(11'h7FF);
    chk("R2 flags latched while masked", status_rd, 11'h109);
    wr_mask(11'h008);
    chk("R4 status is flags AND mask", status_rd, 11'h008);
    chk("R2 no take with gie off", irq_take, 0);
    wr_flags(0);
  endtask

  task automatic t_ir_gate();
    wr_mask(0);
    ir_evt = 1; tick(); ir_evt = 0;
    wr_mask(11'h400);
    chk("R3 IR dropped while masked", status_rd, 0);
    ir_evt = 1; tick(); ir_evt = 0;
    chk("R3 IR set while unmasked", status_rd, 11'h400);
    wr_flags(0);
  endtask

  task automatic t_write_collide();
    wr_mask(11'h7FF);
    wr_flags(11'h0C0);
    chk("R5 write replaces flags", status_rd, 11'h0C0);
    flag_wr = 1; flag_wdata = 0; tmr_ovf = 4'b0001; tick();
    flag_wr = 0; tmr_ovf = 0;
    chk("R5 event wins over clearing write", status_rd, 11'h004);
    wr_flags(0);
    chk("R5 clear", status_rd, 0);
  endtask

  task automatic t_gie();
    wr_mask(11'h7FF);
    wr_flags(11'h020);
    eni = 1; disi = 1; tick(); eni = 0; disi = 0;
    chk("R6 disi beats eni", irq_take, 0);
    eni = 1; tick(); eni = 0;
    chk("R6 eni sets gie", irq_take, 1);
    tick();
    chk("R7 take clears gie", irq_take, 0);
    reti = 1;
    chk("R11 restore follows reti", ctx_restore, 1);
    tick(); reti = 0;
    chk("R6 reti sets gie", irq_take, 1);
    disi = 1; tick(); disi = 0;
    chk("R6 disi clears gie", irq_take, 0);
    wr_flags(0);
  endtask

  task automatic t_take_ctx();
    wr_mask(11'h7FF);
    wr_flags(11'h004);
    acc_i = 8'h5A; stat_i = 8'hC3;
    eni = 1; tick(); eni = 0;
    chk("R7 take", irq_take, 1);
    chk("R7 ctx_save", ctx_save, 1);
    chk("R8 timer0 vector", irq_vector, 10'h3FA);
    tick();
    chk("R7 single take", irq_take, 0);
    chk("R11 acc saved", acc_rst, 8'h5A);
    chk("R11 stat saved", stat_rst, 8'hC3);
    acc_i = 8'h33; stat_i = 8'h11;
    reti = 1; tick(); reti = 0;
    chk("R7 re-entry after reti", irq_take, 1);
    tick();
    chk("R11 nested overwrite acc", acc_rst, 8'h33);
    chk("R11 nested overwrite stat", stat_rst, 8'h11);
    wr_flags(0);
  endtask

  task automatic t_prio();
    wr_mask(11'h7FF);
    wr_flags(11'h400); chk("R8 IR", irq_vector, 10'h3FC);
    wr_flags(11'h220); chk("R8 timer3 over comp3", irq_vector, 10'h3F4);
    wr_flags(11'h040); chk("R8 comp0", irq_vector, 10'h3F2);
    wr_flags(11'h200); chk("R8 comp3", irq_vector, 10'h3EC);
    wr_flags(11'h00A); chk("R8 pin change first", irq_vector, 10'h3FE);
    wr_flags(11'h009); chk("R8 external first", irq_vector, 10'h3FE);
    wr_flags(11'h008); chk("R8 timer1", irq_vector, 10'h3F8);
    wr_mask(11'h7F7);
    wr_flags(11'h208); chk("R8 masked bit skipped", irq_vector, 10'h3EC);
    wr_flags(0);
  endtask

  task automatic t_pinchg();
    wr_mask(11'h002);
    port_pins = 8'h04; tick();
    chk("R9 change vs reset reference", status_rd, 11'h002);
    port_rd = 1; tick(); port_rd = 0;
    wr_flags(0); tick();
    chk("R9 no change after read", status_rd, 0);
    port_pins = 8'h84; tick();
    chk("R9 change vs captured reference", status_rd, 11'h002);
    port_rd = 1; tick(); port_rd = 0;
    wr_flags(0);
  endtask

  task automatic t_wake();
    disi = 1; tick(); disi = 0;
    wr_mask(11'h002);
    sleeping = 1;
    chk("R10 no wake idle", wake, 0);
    port_pins = 8'h80; tick();
    chk("R10 wake on pin change", wake, 1);
    chk("R10 no take with gie off", irq_take, 0);
    wr_mask(0);
    chk("R10 no wake when masked", wake, 0);
    sleeping = 0;
    port_rd = 1; tick(); port_rd = 0;
    wr_flags(0);
  endtask

  initial begin
    repeat (2) tick();
    rst_n = 1; tick();
    t_reset();
    t_masked_latch();
    t_ir_gate();
    t_write_collide();
    t_gie();
    t_take_ctx();
    t_prio();
    t_pinchg();
    t_wake();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule